// File: doc/BRIEF.md
# Infrared Frame Address Filter

This block sits between an infrared frame receiver and the receive FIFO. The receiver delivers a stream of beats, and each beat is a frame start, a data byte or a frame end. The filter treats the first data byte after a frame start as the frame's address. It compares that byte against two programmable 8-bit addresses, each with its own enable bit. The filter then forwards the whole frame to the FIFO write port, or discards the whole frame. When both enable bits are clear, every frame is forwarded. The byte that carries the address is part of the frame and is forwarded too.

The output has an end-of-frame flag on the final byte of each forwarded frame. The filter holds back one byte of a passing frame until it knows whether that byte is the last one, so the flag can be attached to it. Reception can be turned off with a disable pin. It is also turned off whenever the local transmitter is busy. While reception is off, incoming beats are taken and thrown away.

Both stream interfaces use valid/ready. On the output, `out_valid` stays high and `out_data`/`out_last` stay unchanged until `out_ready` accepts the beat. On the input, the upstream must hold `in_valid`, `in_kind` and `in_data` steady until `in_ready` is high at a clock edge. `in_ready` drops only when both of these are true:
- the offered beat would release the held-back byte;
- the output register is full and is not being read.

`in_ready` may therefore depend on `in_kind`.

Top module: `irf_addr_filter`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and no frame is open.
- R2: With `en_i` = 2'b00, every frame that has at least one byte is forwarded, whatever its first byte.
- R3: With only `en_i[0]` set, a frame is forwarded only when its first byte equals address slot 0 (`addr_tab_i[7:0]`).
- R4: With only `en_i[1]` set, a frame is forwarded only when its first byte equals address slot 1 (`addr_tab_i[15:8]`).
- R5: With `en_i` = 2'b11, a frame is forwarded when its first byte equals either slot.
- R6: A rejected frame produces no output beat at all.
- R7: A forwarded frame appears at the output in order, starting with its address byte. `out_last` is 1 on its final byte only. Beat kinds on `in_kind` are: 2'b00 data byte, 2'b01 frame start, 2'b10 frame end, and 2'b11 ignored.
- R8: A frame start followed by a frame end with no byte between them produces no output.
- R9: `en_i` is sampled at the frame start. A change during a frame takes effect at the next frame start.
- R10: While `rx_dis_i` is 1, `in_ready` is 1 and every beat is discarded without changing the frame state.
- R11: While `tx_busy_i` is 1, beats are discarded in the same way as under R10.
- R12: While `out_valid` is 1 and `out_ready` is 0, the output beat stays unchanged. `in_ready` is 0 only in that situation.
- R13: A new frame start while an accepted frame is still open closes that frame, with `out_last` on its held byte. Data bytes arriving outside any frame are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | NADDR | Per-slot address match enables |
| addr_tab_i | input | NADDR*DW | Address slots, slot k at bits [k*DW +: DW] |
| rx_dis_i | input | 1 | Receive disable |
| tx_busy_i | input | 1 | Transmitter active; blocks reception |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted at this edge |
| in_kind | input | 2 | Beat kind (data/start/end/ignored) |
| in_data | input | DW | Data byte |
| out_valid | output | 1 | FIFO write beat valid |
| out_ready | input | 1 | FIFO can take the beat |
| out_data | output | DW | Forwarded byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
The assertions rely on two assumptions about the upstream:
- it keeps an offered beat unchanged until `in_ready` takes it;
- the gating pins change only between clock edges.

The bench changes every input just after an edge and holds each beat until the handshake completes. The bench also throttles `out_ready` in a fixed pattern, so the hold-back register fills and `in_ready` actually drops while the frame content is still compared byte for byte.

// File: rtl/irf_pkg.sv
package irf_pkg;
  typedef enum logic [1:0] {
    BEAT_DATA = 2'b00,
    BEAT_SOF  = 2'b01,
    BEAT_EOF  = 2'b10,
    BEAT_RSVD = 2'b11
  } beat_kind_e;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_ADDR,
    FS_PASS,
    FS_DROP
  } frame_st_e;
endpackage

// File: rtl/irf_match.sv
module irf_match #(
  parameter int DW    = 8,
  parameter int NADDR = 2
) (
  input  logic [DW-1:0]       byte_i,
  input  logic [NADDR*DW-1:0] addr_tab_i,
  input  logic [NADDR-1:0]    en_i,
  output logic                hit_o
);
  logic [NADDR-1:0] slot_hit;

  for (genvar g = 0; g < NADDR; g++) begin : g_slot
    assign slot_hit[g] = en_i[g] && (byte_i == addr_tab_i[g*DW +: DW]);
  end

  // With every slot disabled, checking is off and all frames pass.
  assign hit_o = (en_i == '0) || (|slot_hit);
endmodule

// File: rtl/irf_frame_ctl.sv
module irf_frame_ctl
  import irf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NADDR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic [1:0]       kind_i,
  input  logic [DW-1:0]    data_i,
  input  logic             hit_i,
  input  logic [NADDR-1:0] en_i,
  output logic [NADDR-1:0] en_snap_o,
  output logic             need_push_o,
  output logic             push_o,
  output logic [DW-1:0]    push_data_o,
  output logic             push_last_o
);
  frame_st_e       st;
  logic            pend_v;
  logic [DW-1:0]   pend_d;
  beat_kind_e      kind;

  assign kind = beat_kind_e'(kind_i);

  // The held byte leaves when the next byte arrives (not last) or when the
  // frame closes through an end or a new start (last).
  always_comb begin
    need_push_o = 1'b0;
    push_last_o = 1'b0;
    if (pend_v) begin
      case (kind)
        BEAT_DATA: need_push_o = (st == FS_PASS);
        BEAT_SOF,
        BEAT_EOF: begin
          need_push_o = 1'b1;
          push_last_o = 1'b1;
        end
        default: need_push_o = 1'b0;
      endcase
    end
  end

  assign push_o      = act_i && need_push_o;
  assign push_data_o = pend_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= FS_IDLE;
      pend_v    <= 1'b0;
      pend_d    <= '0;
      en_snap_o <= '0;
    end else if (act_i) begin
      case (kind)
        BEAT_SOF: begin
          st        <= FS_ADDR;
          pend_v    <= 1'b0;
          en_snap_o <= en_i;
        end
        BEAT_EOF: begin
          st     <= FS_IDLE;
          pend_v <= 1'b0;
        end
        BEAT_DATA: begin
          case (st)
            FS_ADDR: begin
              if (hit_i) begin
                st     <= FS_PASS;
                pend_v <= 1'b1;
                pend_d <= data_i;
              end else begin
                st <= FS_DROP;
              end
            end
            FS_PASS: pend_d <= data_i;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irf_out_stage.sv
module irf_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          load_last_i,
  input  logic          out_ready_i,
  output logic          free_o,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o,
  output logic          out_last_o
);
  assign free_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_last_o  <= 1'b0;
    end else if (load_i) begin
      out_valid_o <= 1'b1;
      out_data_o  <= load_data_i;
      out_last_o  <= load_last_i;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irf_addr_filter.sv
module irf_addr_filter #(
  parameter int DW    = 8,
  parameter int NADDR = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NADDR-1:0]    en_i,
  input  logic [NADDR*DW-1:0] addr_tab_i,
  input  logic                rx_dis_i,
  input  logic                tx_busy_i,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          in_kind,
  input  logic [DW-1:0]       in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DW-1:0]       out_data,
  output logic                out_last
);
  logic             gated;
  logic             act;
  logic             hit;
  logic [NADDR-1:0] en_snap;
  logic             need_push;
  logic             push;
  logic [DW-1:0]    push_data;
  logic             push_last;
  logic             free;

  assign gated    = rx_dis_i || tx_busy_i;
  assign in_ready = gated || !need_push || free;
  assign act      = in_valid && in_ready && !gated;

  irf_match #(.DW(DW), .NADDR(NADDR)) u_match (
    .byte_i     (in_data),
    .addr_tab_i (addr_tab_i),
    .en_i       (en_snap),
    .hit_o      (hit)
  );

  irf_frame_ctl #(.DW(DW), .NADDR(NADDR)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .act_i       (act),
    .kind_i      (in_kind),
    .data_i      (in_data),
    .hit_i       (hit),
    .en_i        (en_i),
    .en_snap_o   (en_snap),
    .need_push_o (need_push),
    .push_o      (push),
    .push_data_o (push_data),
    .push_last_o (push_last)
  );

  irf_out_stage #(.DW(DW)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (push),
    .load_data_i (push_data),
    .load_last_i (push_last),
    .out_ready_i (out_ready),
    .free_o      (free),
    .out_valid_o (out_valid),
    .out_data_o  (out_data),
    .out_last_o  (out_last)
  );
endmodule

// File: rtl/irf_addr_filter_chk.sv
module irf_addr_filter_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_dis_i,
  input logic          tx_busy_i,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_last
);
  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R12
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  // R10
  gate_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dis_i || tx_busy_i) |-> in_ready);

  // R11
  gate_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_dis_i || tx_busy_i) && (!out_valid || out_ready)) |=> !out_valid);

  // R1
  always_comb begin
    if (rst_n && !in_valid && !out_valid) begin
      idle_ready_chk: assert (in_ready);
    end
  end
endmodule

bind irf_addr_filter irf_addr_filter_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_dis_i  (rx_dis_i),
  .tx_busy_i (tx_busy_i),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/tb_irf_addr_filter.sv
module tb_irf_addr_filter;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A0 = 8'h3C;
  localparam logic [7:0] A1 = 8'hA5;
  // row: {en[1:0], first byte[7:0], length[3:0], expect forwarded}
  localparam int NROWS = 11;
  localparam logic [14:0] ROWS [NROWS] = '{
    {2'b00, 8'h3C, 4'd4, 1'b1},
    {2'b00, 8'h11, 4'd1, 1'b1},
    {2'b01, 8'h3C, 4'd3, 1'b1},
    {2'b01, 8'hA5, 4'd3, 1'b0},
    {2'b01, 8'h11, 4'd2, 1'b0},
    {2'b10, 8'hA5, 4'd5, 1'b1},
    {2'b10, 8'h3C, 4'd2, 1'b0},
    {2'b11, 8'h3C, 4'd3, 1'b1},
    {2'b11, 8'hA5, 4'd1, 1'b1},
    {2'b11, 8'h77, 4'd4, 1'b0},
    {2'b10, 8'h11, 4'd3, 1'b0}
  };

  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] en_i = 0;
  logic       rx_dis_i = 0;
  logic       tx_busy_i = 0;
  logic       in_valid = 0;
  logic       in_ready;
  logic [1:0] in_kind = 0;
  logic [7:0] in_data = 0;
  logic       out_valid;
  logic       out_ready = 1;
  logic [7:0] out_data;
  logic       out_last;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] cap_d [64];
  logic       cap_l [64];
  int ncap = 0;
  logic [7:0] exp_d [64];
  int nexp = 0;
  logic stall = 0;
  int   stall_cnt = 0;
  int   blocked = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irf_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .addr_tab_i({A1, A0}),
    .rx_dis_i(rx_dis_i), .tx_busy_i(tx_busy_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  always @(negedge clk) begin
    stall_cnt <= stall_cnt + 1;
    out_ready <= stall ? (stall_cnt % 3 == 0) : 1'b1;
  end

  always begin
    @(negedge clk);
    #2;
    if (out_valid && out_ready && ncap < 64) begin
      cap_d[ncap] = out_data;
      cap_l[ncap] = out_last;
      ncap++;
    end
    if (in_valid && !in_ready) blocked++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1; in_kind = k; in_data = d;
    forever begin
      #1;
      if (in_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1;
    in_valid = 0;
  endtask

  task automatic restart();
    repeat (2) @(negedge clk);
    ncap = 0; nexp = 0;
  endtask

  task automatic push_exp(input logic [7:0] b);
    exp_d[nexp] = b;
    nexp++;
  endtask

  task automatic check_out(input string tag);
    bit ok;
    repeat (20) @(negedge clk);
    ok = (ncap == nexp);
    for (int i = 0; i < nexp && i < ncap; i++) begin
      if (cap_d[i] != exp_d[i]) ok = 0;
      if (cap_l[i] != (i == nexp - 1)) ok = 0;
    end
    check(ok, tag, ncap, nexp);
  endtask

  task automatic frame(input logic [7:0] first, input int len, input bit fwd, input int base);
    send(2'b01, 8'h00);
    send(2'b00, first);
    if (fwd) push_exp(first);
    for (int i = 1; i < len; i++) begin
      send(2'b00, 8'(base + i));
      if (fwd) push_exp(8'(base + i));
    end
    send(2'b10, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R1 out_valid after reset", out_valid, 0);
    check(in_ready, "R1 in_ready after reset", in_ready, 1);
    rst_n = 1;

    // table walk: R2 R3 R4 R5 R6 R7
    for (int r = 0; r < NROWS; r++) begin
      logic [14:0] row;
      row = ROWS[r];
      restart();
      en_i = row[14:13];
      frame(row[12:5], int'(row[4:1]), row[0], 8'h40 + r * 8);
      case (row[14:13])
        2'b00: check_out("R2 R7 table row (no check)");
        2'b01: check_out(row[0] ? "R3 R7 table row (slot0)" : "R3 R6 table row (slot0)");
        2'b10: check_out(row[0] ? "R4 R7 table row (slot1)" : "R4 R6 table row (slot1)");
        default: check_out("R5 R6 R7 table row (both)");
      endcase
    end

    // R8: empty frame
    restart();
    en_i = 2'b00;
    send(2'b01, 8'h00);
    send(2'b10, 8'h00);
    check_out("R8 empty frame");

    // R9: enable change inside a frame is deferred
    restart();
    en_i = 2'b00;
    send(2'b01, 8'h00);
    en_i = 2'b01;
    send(2'b00, 8'h11); push_exp(8'h11);
    send(2'b00, 8'h22); push_exp(8'h22);
    send(2'b10, 8'h00);
    check_out("R9 mid-frame enable change ignored");
    restart();
    frame(8'h11, 2, 1'b0, 8'h30);
    check_out("R9 new enable at next start");

    // R10: receive disable in the middle of an accepted frame
    restart();
    en_i = 2'b01;
    send(2'b01, 8'h00);
    send(2'b00, A0); push_exp(A0);
    rx_dis_i = 1;
    @(negedge clk);
    in_valid = 1; in_kind = 2'b00; in_data = 8'hEE;
    #1;
    check(in_ready, "R10 in_ready while disabled", in_ready, 1);
    @(posedge clk); #1; in_valid = 0;
    send(2'b10, 8'h00);
    rx_dis_i = 0;
    send(2'b00, 8'h55); push_exp(8'h55);
    send(2'b10, 8'h00);
    check_out("R10 disabled beats discarded");

    // R11: transmitter busy blocks a frame start and mid-frame bytes
    restart();
    en_i = 2'b00;
    tx_busy_i = 1;
    send(2'b01, 8'h00);
    tx_busy_i = 0;
    send(2'b00, 8'h66);
    send(2'b10, 8'h00);
    check_out("R11 start ignored while transmitting");
    restart();
    send(2'b01, 8'h00);
    send(2'b00, 8'h01); push_exp(8'h01);
    tx_busy_i = 1;
    send(2'b00, 8'h99);
    send(2'b01, 8'h00);
    tx_busy_i = 0;
    send(2'b00, 8'h02); push_exp(8'h02);
    send(2'b10, 8'h00);
    check_out("R11 bytes ignored while transmitting");

    // R13: start inside an open accepted frame closes it; stray bytes dropped
    restart();
    en_i = 2'b01;
    send(2'b01, 8'h00);
    send(2'b00, A0); push_exp(A0);
    send(2'b00, 8'h01); push_exp(8'h01);
    send(2'b00, 8'h02); push_exp(8'h02);
    send(2'b01, 8'h00);
    send(2'b00, 8'h11);
    send(2'b00, 8'h12);
    send(2'b10, 8'h00);
    send(2'b00, A0);
    send(2'b00, 8'h03);
    check_out("R13 restart closes frame, stray bytes dropped");

    // R7: ignored beat kind inside a frame
    restart();
    en_i = 2'b00;
    send(2'b01, 8'h00);
    send(2'b00, 8'h21); push_exp(8'h21);
    send(2'b11, 8'hFF);
    send(2'b00, 8'h22); push_exp(8'h22);
    send(2'b10, 8'h00);
    check_out("R7 ignored beat kind");

    // R12: back-pressure
    restart();
    stall = 1;
    blocked = 0;
    en_i = 2'b10;
    frame(A1, 7, 1'b1, 8'h80);
    check_out("R12 frame intact under back-pressure");
    check(blocked > 0, "R12 in_ready dropped under back-pressure", blocked, 1);
    stall = 0;

    repeat (5) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule